// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Controller

This block sits between a processor's single-word request port and a memory port that moves whole lines. Each request address is divided into a byte offset, a set index and a tag; the tag is compared against every way of the indexed set at the same time. Hits are served from the cache. On a miss the controller loads the line from memory. If the chosen victim holds modified data, the controller first writes that line back to memory.

A build-time parameter picks between two write-policy pairings. The first pairing is write-back with allocation on a write miss. The second is write-through with no allocation: every store goes straight to memory, and a store miss does not load the line. An empty way in the set is always used before an occupied way. The victim among occupied ways comes from an external way-select input. The processor side uses a valid/ready request and a one-cycle completion pulse. The memory side holds a request until it sees an acknowledge.

Top module: `sa_cache`

## Requirements
- R1: With the default geometry, address bits [5:0] are the byte offset, [8:6] select one of 8 sets and [31:9] form the 23-bit tag. Lines with the same set index and different tags occupy different ways at the same time.
- R2: A request hits only when a way of its set is valid and holds an equal tag. Reset clears every valid and dirty bit, so the first access to any line misses.
- R3: A read miss issues exactly one line read (mem_we=0) at the line-aligned address {tag,set,6'b0} and returns the addressed 32-bit word of the fetched line. A following read hit to that line causes no memory request.
- R4: In write-back mode, a write hit updates only the cached word, marks the line dirty and makes no memory request.
- R5: In write-back mode, evicting a dirty line first issues a line write (mem_we=1, mem_wmask all ones) at the victim's address {victim tag,set,6'b0}, carrying its latest contents. The refill read follows.
- R6: In write-back mode, a write miss reads the line from memory and then merges the word into the cache, leaving it dirty, with no memory write.
- R7: In write-through mode, every write issues one memory write whose mask has only bit offset[5:2] set, with the word in that slot. A write hit also updates the cached copy, so a later read hits with the new value.
- R8: In write-through mode, a write miss does not load the line, so the next read of that line misses and refills.
- R9: In write-through mode, an eviction never produces a memory write, and every memory write carries a single-word mask.
- R10: A miss fills the lowest-numbered invalid way of the set. The way-select input is obeyed only when all four ways are valid.
- R11: cpu_ready is high only while idle; each accepted request gives exactly one cpu_done pulse; mem_req, mem_addr and mem_we stay stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller idle and accepting a request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with cpu_done |
| repl_way | input | 2 | Victim way used when the set is full |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wmask | output | 16 | Per-word write enable for the line |
| mem_wdata | output | 512 | Line write data |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | 512 | Line read data, valid with mem_ack |

## Verification
The in-line assertions watch the cycle-level rules on every clock. These include the memory request holding steady until acknowledge and the single completion pulse. They also check that tags in a set stay unique, that empty ways are filled before the way-select input is used, that write-back store hits stay off the memory port, and that write-through mode never issues a multi-word write. Whether the right data comes back, and whether the exact sequence of writebacks and refills matches the policy, can only be shown by the bench scenarios. The bench runs both policy builds against a behavioural cache and memory model, including dirty evictions, allocation differences and a seeded mixed traffic run.

// File: rtl/sa_cache_pkg.sv
// Shared types for the set-associative cache controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sa_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG_CHECK,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } cache_state_e;
endpackage

// File: rtl/sa_cache_store.sv
// Tag, state and line storage for all ways and sets.
// Reads all ways of one set combinationally; one write port updates one way.
// Assumes: a write always leaves the target way valid.
module sa_cache_store #(
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int TAG_W  = 23,
    parameter int LINE_W = 512,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0]              rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][LINE_W-1:0]  rd_line,
    input  logic                         wr_en,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [LINE_W-1:0]            wr_line,
    input  logic                         wr_dirty
);
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [SETS-1:0][WAYS-1:0] dirty_q;
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    logic [LINE_W-1:0]         line_q [SETS][WAYS];

    // State bits: cleared by reset, set or updated by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
            dirty_q[wr_set][wr_way] <= wr_dirty;
        end
    end

    // Tag and data arrays: no reset, written together with the state bits.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            line_q[wr_set][wr_way] <= wr_line;
        end
    end

    // Read out every way of the addressed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_valid[w] = valid_q[rd_set][w];
            rd_dirty[w] = dirty_q[rd_set][w];
            rd_tag[w]   = tag_q[rd_set][w];
            rd_line[w]  = line_q[rd_set][w];
        end
    end

    // R2: one clock of reset leaves no valid or dirty line behind.
    p_reset_clears_r2: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0 && dirty_q == '0));

    // R4: a dirty line is always a valid line.
    p_dirty_implies_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/sa_cache_lookup.sv
// Parallel tag compare and victim selection for one set.
// Assumes: at most one way of a set holds a given valid tag.
module sa_cache_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            req_tag,
    input  logic [WAY_W-1:0]            repl_way,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [WAY_W-1:0]            victim_way
);
    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign hit = |hit_vec;

    // Encode the matching way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Lowest invalid way wins; the external select applies only to a full set.
    always_comb begin
        victim_way = repl_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) victim_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/sa_cache.sv
// Set-associative cache controller between a word port and a line port.
// WRITE_BACK=1: write-back with write-allocate; WRITE_BACK=0: write-through,
// no-write-allocate. Assumes one outstanding request on each side and that
// repl_way stays stable from acceptance until cpu_done.
module sa_cache
    import sa_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 8,
    parameter int LINE_BYTES = 64,
    parameter bit WRITE_BACK = 1'b1,
    localparam int OFS_W    = $clog2(LINE_BYTES),
    localparam int SET_W    = $clog2(SETS),
    localparam int TAG_W    = ADDR_W - SET_W - OFS_W,
    localparam int LINE_W   = LINE_BYTES * 8,
    localparam int WPL      = LINE_W / WORD_W,
    localparam int WIDX_W   = $clog2(WPL),
    localparam int BYTE_OFS = $clog2(WORD_W / 8),
    localparam int WAY_W    = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [WORD_W-1:0] cpu_rdata,
    input  logic [WAY_W-1:0]  repl_way,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WPL-1:0]    mem_wmask,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    cache_state_e         state_q;
    logic                 req_we_q;
    logic [TAG_W-1:0]     req_tag_q;
    logic [SET_W-1:0]     req_set_q;
    logic [WIDX_W-1:0]    req_widx_q;
    logic [WORD_W-1:0]    req_wdata_q;
    logic [WAY_W-1:0]     victim_q;
    logic                 evict_q;
    logic [WORD_W-1:0]    rdata_q;

    logic [WAYS-1:0]              lk_valid, lk_dirty, hit_vec;
    logic [WAYS-1:0][TAG_W-1:0]   lk_tag;
    logic [WAYS-1:0][LINE_W-1:0]  lk_line;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way, victim_way;

    logic                 st_wr_en, st_wr_dirty;
    logic [WAY_W-1:0]     st_wr_way;
    logic [LINE_W-1:0]    st_wr_line;

    logic unused_byte_bits;
    assign unused_byte_bits = ^cpu_addr[BYTE_OFS-1:0];

    function automatic logic [LINE_W-1:0] put_word(logic [LINE_W-1:0] line,
                                                   logic [WIDX_W-1:0] idx,
                                                   logic [WORD_W-1:0] word);
        logic [LINE_W-1:0] r;
        r = line;
        r[idx*WORD_W +: WORD_W] = word;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] get_word(logic [LINE_W-1:0] line,
                                                   logic [WIDX_W-1:0] idx);
        return line[idx*WORD_W +: WORD_W];
    endfunction

    sa_cache_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (req_set_q),
        .rd_valid (lk_valid),
        .rd_dirty (lk_dirty),
        .rd_tag   (lk_tag),
        .rd_line  (lk_line),
        .wr_en    (st_wr_en),
        .wr_way   (st_wr_way),
        .wr_set   (req_set_q),
        .wr_tag   (req_tag_q),
        .wr_line  (st_wr_line),
        .wr_dirty (st_wr_dirty)
    );

    sa_cache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .way_valid  (lk_valid),
        .way_tag    (lk_tag),
        .req_tag    (req_tag_q),
        .repl_way   (repl_way),
        .hit_vec    (hit_vec),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    // Control sequence: accept, compare, optional memory write, optional refill, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_we_q    <= 1'b0;
            req_tag_q   <= '0;
            req_set_q   <= '0;
            req_widx_q  <= '0;
            req_wdata_q <= '0;
            victim_q    <= '0;
            evict_q     <= 1'b0;
            rdata_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cpu_valid) begin
                    req_we_q    <= cpu_we;
                    req_tag_q   <= cpu_addr[ADDR_W-1 -: TAG_W];
                    req_set_q   <= cpu_addr[OFS_W +: SET_W];
                    req_widx_q  <= cpu_addr[OFS_W-1:BYTE_OFS];
                    req_wdata_q <= cpu_wdata;
                    state_q     <= ST_TAG_CHECK;
                end
                ST_TAG_CHECK: begin
                    victim_q <= victim_way;
                    evict_q  <= 1'b0;
                    if (hit) begin
                        rdata_q <= get_word(lk_line[hit_way], req_widx_q);
                        state_q <= (req_we_q && !WRITE_BACK) ? ST_WRITEBACK : ST_RESPOND;
                    end else if (req_we_q && !WRITE_BACK) begin
                        state_q <= ST_WRITEBACK;
                    end else if (WRITE_BACK && lk_valid[victim_way] && lk_dirty[victim_way]) begin
                        evict_q <= 1'b1;
                        state_q <= ST_WRITEBACK;
                    end else begin
                        state_q <= ST_REFILL;
                    end
                end
                ST_WRITEBACK: if (mem_ack) state_q <= evict_q ? ST_REFILL : ST_RESPOND;
                ST_REFILL: if (mem_ack) begin
                    rdata_q <= get_word(mem_rdata, req_widx_q);
                    state_q <= ST_RESPOND;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Storage update: word merge on a write hit, line install on a refill.
    always_comb begin
        st_wr_en    = 1'b0;
        st_wr_way   = hit_way;
        st_wr_line  = put_word(lk_line[hit_way], req_widx_q, req_wdata_q);
        st_wr_dirty = WRITE_BACK | lk_dirty[hit_way];
        if (state_q == ST_TAG_CHECK && hit && req_we_q) begin
            st_wr_en = 1'b1;
        end else if (state_q == ST_REFILL && mem_ack) begin
            st_wr_en    = 1'b1;
            st_wr_way   = victim_q;
            st_wr_line  = req_we_q ? put_word(mem_rdata, req_widx_q, req_wdata_q) : mem_rdata;
            st_wr_dirty = req_we_q;
        end
    end

    // Memory port: victim line write, single-word store, or line read.
    always_comb begin
        mem_req   = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
        mem_we    = (state_q == ST_WRITEBACK);
        mem_addr  = {req_tag_q, req_set_q, {OFS_W{1'b0}}};
        mem_wmask = '0;
        mem_wdata = '0;
        if (state_q == ST_WRITEBACK) begin
            if (evict_q) begin
                mem_addr  = {lk_tag[victim_q], req_set_q, {OFS_W{1'b0}}};
                mem_wmask = '1;
                mem_wdata = lk_line[victim_q];
            end else begin
                mem_wmask = WPL'(1) << req_widx_q;
                mem_wdata = put_word('0, req_widx_q, req_wdata_q);
            end
        end
    end

    assign cpu_ready = (state_q == ST_IDLE);
    assign cpu_done  = (state_q == ST_RESPOND);
    assign cpu_rdata = rdata_q;

    // R11: an unacknowledged memory request holds its command and address.
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: completion is a single pulse followed by readiness.
    p_single_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> (!cpu_done && cpu_ready));

    // R1: a tag never matches in two ways of one set.
    p_hit_unique_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAG_CHECK) |-> $onehot0(hit_vec));

    // R10: a set with room never loses a valid line on a miss.
    p_fill_empty_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAG_CHECK && !hit && !(&lk_valid)) |-> !lk_valid[victim_way]);

    // R4: write-back store hits go straight to completion.
    p_wb_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK && state_q == ST_TAG_CHECK && hit && req_we_q) |=> (cpu_done && !mem_req));

    // R9: write-through builds never write more than one word.
    p_wt_word_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!WRITE_BACK && mem_req && mem_we) |-> ($countones(mem_wmask) == 1));
endmodule

// File: tb/sa_cache_tb.sv
// One policy build plus its behavioural cache/memory model and scenarios.
module sa_cache_harness #(parameter bit WB = 1'b1) (
    input  logic clk,
    input  logic rst_n,
    output int   n_err,
    output int   n_chk,
    output logic fin
);
    logic         cpu_valid, cpu_ready, cpu_we, cpu_done;
    logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
    logic [1:0]   repl_way;
    logic         mem_req, mem_we, mem_ack;
    logic [31:0]  mem_addr;
    logic [15:0]  mem_wmask;
    logic [511:0] mem_wdata, mem_rdata;

    sa_cache #(.WRITE_BACK(WB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .repl_way(repl_way),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wmask(mem_wmask), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct packed { logic we; logic [31:0] addr; logic [15:0] mask; } op_t;
    op_t          expq[$];
    logic [22:0]  m_tag [8][4];
    bit           m_val [8][4];
    bit           m_dty [8][4];
    logic [31:0]  arch  [int];
    logic [511:0] mline [int];
    string        cur = "R11";
    string        pfx;

    function automatic logic [31:0] pat(int ln, int i);
        return {ln[15:0], 8'hC3, i[7:0]};
    endfunction

    function automatic logic [31:0] arch_rd(logic [31:0] a);
        int k = int'(a >> 2);
        if (arch.exists(k)) return arch[k];
        return pat(int'(a >> 6), int'(a[5:2]));
    endfunction

    function automatic logic [511:0] line_rd(int ln);
        logic [511:0] r;
        if (mline.exists(ln)) return mline[ln];
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = pat(ln, i);
        return r;
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s %s: got %h expected %h", pfx, rq, what, act, exp);
        end
    endtask

    // Memory responder: fixed latency, checks each request against the model queue.
    initial begin : responder
        int lat = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && rst_n) begin
                if (lat < 2) lat++;
                else begin
                    op_t e;
                    lat = 0;
                    chk(expq.size() > 0, cur, "unexpected memory request addr", mem_addr, 32'h0);
                    if (expq.size() > 0) begin
                        e = expq.pop_front();
                        chk(mem_we == e.we, cur, "memory command", {31'h0, mem_we}, {31'h0, e.we});
                        chk(mem_addr == e.addr, cur, "memory address", mem_addr, e.addr);
                        if (e.we) chk(mem_wmask == e.mask, cur, "write mask", {16'h0, mem_wmask}, {16'h0, e.mask});
                    end
                    if (mem_we) begin
                        logic [511:0] l = line_rd(int'(mem_addr >> 6));
                        for (int i = 0; i < 16; i++) begin
                            if (mem_wmask[i]) begin
                                chk(mem_wdata[i*32 +: 32] == arch_rd(mem_addr + 32'(4*i)), cur,
                                    "written word", mem_wdata[i*32 +: 32], arch_rd(mem_addr + 32'(4*i)));
                                l[i*32 +: 32] = mem_wdata[i*32 +: 32];
                            end
                        end
                        mline[int'(mem_addr >> 6)] = l;
                    end else begin
                        mem_rdata = line_rd(int'(mem_addr >> 6));
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // Reference step: predicts memory traffic and updates model state.
    task automatic model(bit we, logic [31:0] a, logic [31:0] d, logic [1:0] rp, output logic [31:0] exp_rd);
        int s = int'(a[8:6]);
        int hw = -1;
        int v = -1;
        logic [31:0] la = {a[31:6], 6'b0};
        logic [15:0] mk = 16'h1 << a[5:2];
        exp_rd = arch_rd(a);
        for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == a[31:9]) hw = w;
        if (hw >= 0) begin
            if (we) begin
                if (WB) m_dty[s][hw] = 1'b1;
                else expq.push_back(op_t'{1'b1, la, mk});
                arch[int'(a >> 2)] = d;
            end
        end else if (we && !WB) begin
            expq.push_back(op_t'{1'b1, la, mk});
            arch[int'(a >> 2)] = d;
        end else begin
            for (int w = 0; w < 4; w++) if (!m_val[s][w] && v < 0) v = w;
            if (v < 0) v = int'(rp);
            if (WB && m_dty[s][v])
                expq.push_back(op_t'{1'b1, {m_tag[s][v], a[8:6], 6'b0}, 16'hFFFF});
            expq.push_back(op_t'{1'b0, la, 16'h0});
            m_tag[s][v] = a[31:9];
            m_val[s][v] = 1'b1;
            m_dty[s][v] = we;
            if (we) arch[int'(a >> 2)] = d;
        end
    endtask

    task automatic do_req(bit we, logic [31:0] a, logic [31:0] d, logic [1:0] rp, string rq);
        logic [31:0] exp_rd;
        int n = 0;
        model(we, a, d, rp, exp_rd);
        cur = rq;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; repl_way = rp;
        @(negedge clk);
        cpu_valid = 1'b0;
        while (!cpu_done && n < 100) begin @(negedge clk); n++; end
        chk(cpu_done, rq, "completion pulse", {31'h0, cpu_done}, 32'h1);
        if (!we) chk(cpu_rdata == exp_rd, rq, "read data", cpu_rdata, exp_rd);
        chk(expq.size() == 0, rq, "missing memory requests", expq.size(), 32'h0);
        expq.delete();
    endtask

    // Scenario sequence for this policy build.
    initial begin : scenario
        n_err = 0; n_chk = 0; fin = 1'b0;
        pfx = WB ? "[write-back]" : "[write-through]";
        cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; repl_way = '0;
        for (int s = 0; s < 8; s++) for (int w = 0; w < 4; w++) begin
            m_val[s][w] = 1'b0; m_dty[s][w] = 1'b0; m_tag[s][w] = '0;
        end
        @(posedge rst_n);
        @(negedge clk);
        chk(cpu_ready, "R11", "ready after reset", {31'h0, cpu_ready}, 32'h1);
        chk(!mem_req && !cpu_done, "R2", "idle outputs after reset", {30'h0, mem_req, cpu_done}, 32'h0);
        do_req(1'b0, 32'h0000_0040, 32'h0, 2'd0, "R2 R3 cold read miss");
        do_req(1'b0, 32'h0000_0044, 32'h0, 2'd0, "R3 read hit");
        do_req(1'b1, 32'h0000_0048, 32'h0000_1111, 2'd0, WB ? "R4 write hit" : "R7 write hit");
        do_req(1'b0, 32'h0000_0048, 32'h0, 2'd0, "R7 R4 read after write");
        do_req(1'b0, 32'h0000_0240, 32'h0, 2'd3, "R1 R10 fill way1");
        do_req(1'b0, 32'h0000_0440, 32'h0, 2'd3, "R1 R10 fill way2");
        do_req(1'b0, 32'h0000_0640, 32'h0, 2'd3, "R1 R10 fill way3");
        do_req(1'b0, 32'h0000_0840, 32'h0, 2'd0, WB ? "R5 dirty eviction" : "R9 clean eviction");
        do_req(1'b0, 32'h0000_0048, 32'h0, 2'd1, "R10 R5 evicted data returns");
        do_req(1'b1, 32'h1000_0084, 32'hCAFE_0001, 2'd0, WB ? "R6 write miss allocate" : "R8 write miss around");
        do_req(1'b0, 32'h1000_0084, 32'h0, 2'd0, WB ? "R6 read of allocated line" : "R8 read misses after store");
        do_req(1'b1, 32'h1000_0080, 32'hCAFE_0002, 2'd0, "R7 R4 second word write");
        do_req(1'b0, 32'h1000_0080, 32'h0, 2'd0, "R7 R4 second word readback");
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a = {20'h0, 3'(($urandom % 6)), 1'b0, 2'($urandom % 2), 4'($urandom % 16), 2'b00};
            a = {14'h0, a[17:0]} & 32'h0000_0FFC;
            a = {20'h0, 3'(a[11:9] % 6), a[8:0]};
            do_req(1'($urandom % 2), a, $urandom, 2'($urandom % 4), "R3 R5 R7 R10 mixed traffic");
        end
        fin = 1'b1;
    end
endmodule

// Top bench: clock, reset, watchdog, both policy builds, summary.
module sa_cache_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   e_wb, c_wb, e_wt, c_wt;
    logic f_wb, f_wt;

    always #4 clk = ~clk;

    sa_cache_harness #(.WB(1'b1)) h_wb (.clk(clk), .rst_n(rst_n), .n_err(e_wb), .n_chk(c_wb), .fin(f_wb));
    sa_cache_harness #(.WB(1'b0)) h_wt (.clk(clk), .rst_n(rst_n), .n_err(e_wt), .n_chk(c_wt), .fin(f_wt));

    // Reset pulse.
    initial begin
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    end

    // Watchdog and final report.
    initial begin : supervisor
        int cyc = 0;
        int extra_e = 0;
        int extra_c = 0;
        while (!(f_wb === 1'b1 && f_wt === 1'b1) && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 150000) begin
            extra_e = 1; extra_c = 1;
            $display("FAIL R11 watchdog: got still busy expected all scenarios done");
        end
        repeat (2) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", e_wb + e_wt + extra_e, c_wb + c_wt + extra_c);
        $finish;
    end
endmodule